// File: doc/BRIEF.md
# Scalar Bit-Manipulation Unit

This block is a 64-bit execution unit for six scalar bit operations, picked by a 3-bit operation select: field extract, and-not, isolate lowest set bit, mask through lowest set bit, clear lowest set bit, and trailing-zero count. An operation is accepted on any clock edge where `in_valid` is high. Its result and two status flags, carry and zero, appear on registered outputs on the next edge, together with `out_valid`.

A single-source operation works on `src_a`. And-not combines `src_a` and `src_b`. Field extract reads its data from `src_a` and its control word from `src_b`. A two-state machine runs the output strobe. `ST_IDLE` means nothing is presented. `ST_EMIT` means a result is presented. The transition `ACCEPT` (IDLE→EMIT or EMIT→EMIT) is taken whenever `in_valid` is high. The transition `DRAIN` (EMIT→IDLE) is taken when `in_valid` is low. When `in_valid` is low the machine stays in IDLE (`REST`). Reset forces `ST_IDLE`.

Operation codes: 0 field extract, 1 and-not, 2 isolate, 3 mask, 4 clear-lowest, 5 trailing-zero count. Codes 6 and 7 are unused.

Top module: `bitop_unit`

## Requirements
- R1: Field extract (op 0) takes its start index `s` from `src_b[7:0]` and its length `n` from `src_b[15:8]`. It returns `src_a` bits s to s+n-1, right-aligned, and every higher result bit is zero. For example, data 0x50 with s=4 and n=4 gives 0x5.
- R2: For field extract, a start index of 64 or more gives 0 and a length of 0 gives 0. A field that runs past bit 63 is cut off at bit 63, so s=0 with n=255 returns `src_a` unchanged.
- R3: And-not (op 1) returns `~src_a & src_b`. For example, 0x40 with 0x5D gives 0x1D.
- R4: Isolate (op 2) returns only the lowest set bit of `src_a`, or 0 when `src_a` is 0. For example, 0xD0 gives 0x10.
- R5: Mask (op 3) returns ones from bit 0 up to and including the lowest set bit of `src_a`. For example, 0x30 gives 0x1F. A zero source gives all ones.
- R6: Clear-lowest (op 4) returns `src_a` with its lowest set bit cleared. For example, 0x30 gives 0x20, and a zero source gives 0.
- R7: Trailing-zero count (op 5) returns the number of zero bits below the lowest set bit of `src_a`, or 64 when `src_a` is 0. For example, 0x90 gives 4.
- R8: `cf` is 1 exactly when `src_a` is 0 for ops 2, 3, 4 and 5. `cf` is 0 for ops 0 and 1.
- R9: For ops 0 to 4, `zf` is 1 exactly when the 64-bit result is 0. For op 5, `zf` equals `src_a[0]`.
- R10: `out_valid` is high exactly in the cycle after an edge with `in_valid` high. With `in_valid` low the result and flags keep their values.
- R11: While the active-low synchronous reset `rst_n` is 0, the next edge clears `res`, `cf`, `zf` and `out_valid`.
- R12: Ops 6 and 7 give result 0 with `cf` and `zf` both 0, and still raise `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation accepted on this edge |
| op | input | 3 | Operation select |
| src_a | input | 64 | First operand / data / single source |
| src_b | input | 64 | Second operand / extract control |
| res | output | 64 | Registered result |
| cf | output | 1 | Carry flag |
| zf | output | 1 | Zero flag |
| out_valid | output | 1 | Result valid strobe |

## Verification
Two things can happen on the same edge. A new operation can be accepted while the previous result is still on the outputs, and `ACCEPT` then fires from `ST_EMIT`. The bench provokes this by issuing operations on back-to-back cycles with different ops and operand patterns, including zero sources. A scoreboard holds one expected entry per issued operation and compares each presented result in order. Any result lost or duplicated across the overlap shows up as a mismatch or as a leftover entry.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    parameter int unsigned DW = 64;
    localparam int unsigned CW = $clog2(DW + 1);

    typedef enum logic [2:0] {
        OP_FEXT = 3'd0,
        OP_ANDN = 3'd1,
        OP_ISOL = 3'd2,
        OP_MSKL = 3'd3,
        OP_CLRL = 3'd4,
        OP_TZC  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } vstate_t;
endpackage

// File: rtl/bitop_fext.sv
module bitop_fext #(
    parameter int unsigned W  = 64,
    parameter int unsigned BW = 8
) (
    input  logic [W-1:0]  data,
    input  logic [BW-1:0] start,
    input  logic [BW-1:0] len,
    output logic [W-1:0]  field
);
    logic [W-1:0] shifted;
    logic [W-1:0] keep;

    // Per-bit keep mask: bit i survives when i < len (clipping is implicit).
    for (genvar i = 0; i < W; i++) begin : g_keep
        assign keep[i] = (32'(len) > i);
    end

    always_comb begin
        shifted = data >> start;
        if (32'(start) >= W) begin
            field = '0;
        end else begin
            field = shifted & keep;
        end
    end
endmodule

// File: rtl/bitop_lowbit.sv
module bitop_lowbit #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] isol,
    output logic [W-1:0] mskl,
    output logic [W-1:0] clrl,
    output logic         src_zero
);
    logic [W-1:0] dec;
    logic [W-1:0] neg;

    always_comb begin
        dec      = src - W'(1);
        neg      = W'(0) - src;
        isol     = src & neg;
        mskl     = src ^ dec;
        clrl     = src & dec;
        src_zero = (src == '0);
    end
endmodule

// File: rtl/bitop_tzc.sv
module bitop_tzc #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  src,
    output logic [CW-1:0] count
);
    always_comb begin
        count = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (src[i]) begin
                count = CW'(i);
            end
        end
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic [DW-1:0] res,
    output logic          cf,
    output logic          zf,
    output logic          out_valid
);
    localparam int unsigned BW = 8;

    op_t           op_e;
    logic [DW-1:0] fext_r, isol_r, mskl_r, clrl_r;
    logic [CW-1:0] tz_cnt;
    logic          a_zero;
    logic [DW-1:0] nxt_res;
    logic          nxt_cf, nxt_zf;
    vstate_t       state, state_nxt;

    assign op_e = op_t'(op);

    bitop_fext #(.W(DW), .BW(BW)) u_fext (
        .data  (src_a),
        .start (src_b[BW-1:0]),
        .len   (src_b[2*BW-1:BW]),
        .field (fext_r)
    );

    bitop_lowbit #(.W(DW)) u_lowbit (
        .src      (src_a),
        .isol     (isol_r),
        .mskl     (mskl_r),
        .clrl     (clrl_r),
        .src_zero (a_zero)
    );

    bitop_tzc #(.W(DW), .CW(CW)) u_tzc (
        .src   (src_a),
        .count (tz_cnt)
    );

    always_comb begin
        nxt_res = '0;
        nxt_cf  = 1'b0;
        nxt_zf  = 1'b0;
        unique case (op_e)
            OP_FEXT: begin nxt_res = fext_r;          nxt_zf = (fext_r == '0); end
            OP_ANDN: begin nxt_res = ~src_a & src_b;  nxt_zf = ((~src_a & src_b) == '0); end
            OP_ISOL: begin nxt_res = isol_r; nxt_cf = a_zero; nxt_zf = (isol_r == '0); end
            OP_MSKL: begin nxt_res = mskl_r; nxt_cf = a_zero; nxt_zf = (mskl_r == '0); end
            OP_CLRL: begin nxt_res = clrl_r; nxt_cf = a_zero; nxt_zf = (clrl_r == '0); end
            OP_TZC:  begin nxt_res = DW'(tz_cnt); nxt_cf = a_zero; nxt_zf = src_a[0]; end
            default: begin nxt_res = '0; nxt_cf = 1'b0; nxt_zf = 1'b0; end
        endcase
    end

    // Valid-strobe state machine: ACCEPT / DRAIN / REST transitions.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nxt = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
            cf  <= 1'b0;
            zf  <= 1'b0;
        end else if (in_valid) begin
            res <= nxt_res;
            cf  <= nxt_cf;
            zf  <= nxt_zf;
        end
    end

    assign out_valid = (state == ST_EMIT);

    a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res) && $stable(cf) && $stable(zf));
    a_r4_isol_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) == OP_ISOL |-> $onehot0(res));
    a_r7_tz_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) == OP_TZC |-> res <= DW'(DW));
    a_r8_andn_cf: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(op) == OP_ANDN || $past(op) == OP_FEXT) |-> !cf);
    a_r12_unused: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) > 3'd5 |-> res == '0 && !cf && !zf);
endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [63:0] res;
    logic        cf, zf, out_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [65:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_res = '0;

    always #5 clk = ~clk;

    bitop_unit u_bitop_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .res(res), .cf(cf), .zf(zf),
        .out_valid(out_valid)
    );

    function automatic logic [65:0] model(input logic [2:0] o,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r = '0;
        logic c = 1'b0, z;
        int s = int'(b[7:0]);
        int n = int'(b[15:8]);
        int low = 64;
        for (int i = 63; i >= 0; i--) if (a[i]) low = i;
        case (o)
            3'd0: for (int i = 0; i < 64; i++)
                      if (i < n && s + i < 64) r[i] = a[s + i];
            3'd1: for (int i = 0; i < 64; i++) r[i] = !a[i] && b[i];
            3'd2: if (low < 64) r[low] = 1'b1;
            3'd3: for (int i = 0; i < 64; i++) r[i] = (i <= low);
            3'd4: begin r = a; if (low < 64) r[low] = 1'b0; end
            3'd5: r = 64'(low);
            default: r = '0;
        endcase
        if (o >= 3'd2 && o <= 3'd5) c = (a == '0);
        if (o == 3'd5)      z = a[0];
        else if (o > 3'd5)  z = 1'b0;
        else                z = (r == '0);
        return {c, z, r};
    endfunction

    task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual cf=%0b zf=%0b res=%h expected cf=%0b zf=%0b res=%h",
                     tag, act[65], act[64], act[63:0], exp[65], exp[64], exp[63:0]);
        end
    endtask

    task automatic issue(input string tag, input logic [2:0] o,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = o; src_a = a; src_b = b;
        exp_q.push_back(model(o, a, b));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; op = 3'd7; src_a = '1; src_b = '1;
        end
    endtask

    // Monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                check("R10 spurious out_valid", {cf, zf, res}, 66'h0);
                if ({cf, zf, res} == 66'h0) begin
                    errors++;
                    $display("FAIL R10: actual out_valid=1 expected out_valid=0");
                end
            end else begin
                check(tag_q.pop_front(), {cf, zf, res}, exp_q.pop_front());
                last_res = res;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset state", {cf, zf, res}, 66'h0);
        check("R11 reset out_valid", {65'h0, out_valid}, 66'h0);
        @(negedge clk); rst_n = 1'b1;

        issue("R1 fext 0x50 s4 n4",  3'd0, 64'h50, 64'h0404);
        issue("R1 fext mid field",   3'd0, 64'hDEAD_BEEF_1234_5678, 64'h1010);
        issue("R2 fext start 64",    3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0840);
        issue("R2 fext start 200",   3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10C8);
        issue("R2 fext len 0",       3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0005);
        issue("R2 fext clip s60 n10",3'd0, 64'hA000_0000_0000_0000, 64'h0A3C);
        issue("R2 fext whole n255",  3'd0, 64'h0123_4567_89AB_CDEF, 64'hFF00);
        issue("R3 andn 0x40 0x5D",   3'd1, 64'h40, 64'h5D);
        issue("R3 andn all ones",    3'd1, '1, '1);
        issue("R4 isol 0xD0",        3'd2, 64'hD0, 64'h0);
        issue("R4 R8 isol zero",     3'd2, 64'h0, 64'h0);
        issue("R5 mskl 0x30",        3'd3, 64'h30, 64'h0);
        issue("R5 R8 mskl zero",     3'd3, 64'h0, 64'h0);
        issue("R6 clrl 0x30",        3'd4, 64'h30, 64'h0);
        issue("R6 R8 clrl zero",     3'd4, 64'h0, 64'h0);
        issue("R6 R9 clrl msb only", 3'd4, 64'h8000_0000_0000_0000, 64'h0);
        issue("R7 tz 0x90",          3'd5, 64'h90, 64'h0);
        issue("R7 R9 tz bit0",       3'd5, 64'h1, 64'h0);
        issue("R7 R8 tz zero",       3'd5, 64'h0, 64'h0);
        issue("R7 tz msb",           3'd5, 64'h8000_0000_0000_0000, 64'h0);
        issue("R12 op6",             3'd6, 64'h1234, 64'h5678);
        issue("R12 op7",             3'd7, 64'h0, 64'hFFFF);
        idle(3);
        #2;
        check("R10 idle out_valid low", {65'h0, out_valid}, 66'h0);
        check("R10 result held", {2'b00, res}, {2'b00, last_res});

        issue("R9 andn zero result", 3'd1, '1, 64'h00FF);
        idle(1);
        issue("R1 R10 after gap",    3'd0, 64'hF0, 64'h0404);
        idle(2);

        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11 reset clears result", {cf, zf, res}, 66'h0);
        check("R11 reset clears valid", {65'h0, out_valid}, 66'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(1);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: actual pending=%0d expected pending=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule